// File: doc/BRIEF.md
# Descriptor-Chain DMA Engine

This block is the internal DMA mover of a card host controller. Software builds a list of four-word descriptors in memory, writes the list start address, and sets the run bit. The engine then fetches each descriptor and checks that it owns it. It moves the described buffer between memory and the card data FIFO, then writes the first descriptor word back with ownership handed to software. After that it moves on to the next descriptor, until it closes one marked as the last.

Each descriptor has four words. Word 0 carries the flags. Word 1 carries the byte length. Word 2 is the buffer address, and word 3 is the link to the next descriptor. The direction of a buffer comes from the card-side data engine through `tx_dir`. It is sampled when each descriptor is checked. The engine issues one memory access at a time on a simple request/ready port, and read data returns later on `mem_rvalid`. The status register shows sticky event bits and the live state code, and an interrupt line combines the status bits with an enable register.

Top module: `dchain_dma`

## Requirements
- R1: After reset every register reads 0, the state code is 0 (idle), `irq` is low, and no memory or FIFO access is made.
- R2: Register offsets are control 0x80, list base 0x84, status 0x88 and interrupt enable 0x8C. Base and enable read back as written. Control bit 1 (fixed burst) and bit 7 (run) read back as written. Control bit 0 always reads 0.
- R3: A control write with bit 7 set and bit 0 clear, made while idle, starts the engine. It reads the descriptor at the list base as four single-word reads at offsets +0, +4, +8 and +12, with never more than one read outstanding.
- R4: If word 0 bit 31 (ownership) of a fetched descriptor is 0, the engine makes no buffer access and sets status bit 4 (descriptor unavailable). It then holds state code 1 (suspended) until another control write with bit 7 set, which refetches the same descriptor.
- R5: The low SZ_BITS bits of word 1 give the buffer length in bytes, and the value 0 means 2^SZ_BITS bytes. The engine moves length/4 words, starting at the word 2 address and stepping by 4.
- R6: With `tx_dir`=1, memory words are pushed into the FIFO in address order, and no push happens while `fifo_full` is high. With `tx_dir`=0, FIFO words are popped and written to memory in order, and no pop happens while `fifo_empty` is high.
- R7: On close, word 0 is written back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R8: On close, status bit 0 (transmit done) or bit 1 (receive done) is set according to the direction, unless word 0 bit 1 (no completion interrupt) is set. Status bit 8 reads as bit 0 OR bit 1, and status bit 9 reads as bit 4.
- R9: After close, word 0 bit 2 (last) returns the engine to idle. Otherwise bit 4 (chain) makes word 3 the next descriptor address. Without chain, bit 5 (end of ring) wraps to the list base, and otherwise the next descriptor follows at +16.
- R10: Status bits 0, 1 and 4 are cleared by writing 1 to them, and a new event in the same cycle wins. Status bits 16:13 give the state code: 0 idle, 1 suspended, 2 descriptor read, 3 descriptor check, 4 read request wait, 5 write request wait, 6 read, 7 write, 8 close.
- R11: `irq` is high whenever any status bit in 9:0 is set and its enable bit is set.
- R12: A control write with bit 0 set returns the engine to idle and clears the run bit, the fixed burst bit and all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_dir | input | 1 | 1 = memory to FIFO, 0 = FIFO to memory |
| fifo_push | output | 1 | Push a word into the transmit FIFO |
| fifo_wdata | output | 32 | Word pushed |
| fifo_full | input | 1 | Transmit FIFO has no room |
| fifo_pop | output | 1 | Pop the head of the receive FIFO |
| fifo_rdata | input | 32 | Receive FIFO head word |
| fifo_empty | input | 1 | Receive FIFO has no data |

## Verification
A wrong walker state shows up within a few cycles in the state code of the status register. It also shows up in the memory request stream, as a wrong fetch offset, a missing write-back, or a buffer word sent to the wrong address. A wrong length decode or link choice shows only when the descriptor closes, as a wrong count of FIFO words or memory writes. A wrong next fetch address shows when the descriptor after it is fetched. Status and interrupt faults are visible on `reg_rdata` and `irq` one cycle after the event that sets them.

// File: rtl/dchain_pkg.sv
// Shared definitions for the descriptor-chain DMA engine.
// Assumes 32-bit data words and descriptors aligned to 16 bytes.
package dchain_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_SUSP  = 4'd1,
        ST_DRD   = 4'd2,
        ST_DCHK  = 4'd3,
        ST_RDREQ = 4'd4,
        ST_WRREQ = 4'd5,
        ST_RD    = 4'd6,
        ST_WR    = 4'd7,
        ST_CLOSE = 4'd8
    } dma_state_e;

    // descriptor word 0 flag positions
    localparam int F_NOIRQ = 1;
    localparam int F_LAST  = 2;
    localparam int F_CHAIN = 4;
    localparam int F_RING  = 5;
    localparam int F_OWN   = 31;

    // register offsets
    localparam int OFS_CTRL = 'h80;
    localparam int OFS_BASE = 'h84;
    localparam int OFS_STS  = 'h88;
    localparam int OFS_IEN  = 'h8C;

    // control bits
    localparam int C_SRST = 0;
    localparam int C_FB   = 1;
    localparam int C_RUN  = 7;

    // status bits
    localparam int S_TXD  = 0;
    localparam int S_RXD  = 1;
    localparam int S_DU   = 4;
    localparam int S_NSUM = 8;
    localparam int S_ASUM = 9;
    localparam int S_STLO = 13;

endpackage

// File: rtl/dchain_regs.sv
// Register file of the DMA engine: control, list base, write-1-to-clear
// status with the live state code, interrupt enable and the irq line.
// Assumes RAW >= 8 so that all offsets are reachable.
module dchain_regs
    import dchain_pkg::*;
#(
    parameter int RAW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  dma_state_e       state,
    input  logic             set_tx,
    input  logic             set_rx,
    input  logic             set_du,
    output logic [31:0]      base,
    output logic             kick,
    output logic             sreset,
    output logic             irq
);

    logic        run_q, fb_q;
    logic        st_tx, st_rx, st_du;
    logic [31:0] ien_q;
    logic [31:0] sts_word;
    logic        wr_ctrl, wr_sts;

    // decode register writes
    always_comb begin
        wr_ctrl = reg_we && (reg_addr == RAW'(OFS_CTRL));
        wr_sts  = reg_we && (reg_addr == RAW'(OFS_STS));
        sreset  = wr_ctrl && reg_wdata[C_SRST];
        kick    = wr_ctrl && reg_wdata[C_RUN] && !reg_wdata[C_SRST];
    end

    // register state and sticky status updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            fb_q  <= 1'b0;
            base  <= '0;
            ien_q <= '0;
            st_tx <= 1'b0;
            st_rx <= 1'b0;
            st_du <= 1'b0;
        end else if (sreset) begin
            run_q <= 1'b0;
            fb_q  <= 1'b0;
            st_tx <= 1'b0;
            st_rx <= 1'b0;
            st_du <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run_q <= reg_wdata[C_RUN];
                fb_q  <= reg_wdata[C_FB];
            end
            if (reg_we && reg_addr == RAW'(OFS_BASE)) base  <= reg_wdata;
            if (reg_we && reg_addr == RAW'(OFS_IEN))  ien_q <= reg_wdata;
            st_tx <= set_tx | (st_tx & ~(wr_sts & reg_wdata[S_TXD]));
            st_rx <= set_rx | (st_rx & ~(wr_sts & reg_wdata[S_RXD]));
            st_du <= set_du | (st_du & ~(wr_sts & reg_wdata[S_DU]));
        end
    end

    // assemble the status word
    always_comb begin
        sts_word                   = '0;
        sts_word[S_TXD]            = st_tx;
        sts_word[S_RXD]            = st_rx;
        sts_word[S_DU]             = st_du;
        sts_word[S_NSUM]           = st_tx | st_rx;
        sts_word[S_ASUM]           = st_du;
        sts_word[S_STLO+3:S_STLO]  = state;
    end

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RAW'(OFS_CTRL)) begin
            reg_rdata[C_RUN] = run_q;
            reg_rdata[C_FB]  = fb_q;
        end else if (reg_addr == RAW'(OFS_BASE)) begin
            reg_rdata = base;
        end else if (reg_addr == RAW'(OFS_STS)) begin
            reg_rdata = sts_word;
        end else if (reg_addr == RAW'(OFS_IEN)) begin
            reg_rdata = ien_q;
        end
    end

    // interrupt line
    assign irq = |(sts_word[9:0] & ien_q[9:0]);

    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && reg_wdata == 32'hFFFF_FFFF && !set_tx && !set_rx && !set_du)
        |=> (sts_word[9:0] == 10'd0));

    a_r12_sreset_stops: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (!run_q && !st_tx && !st_rx && !st_du));

endmodule

// File: rtl/dchain_walker.sv
// Descriptor walker: fetches four-word descriptors, checks ownership,
// moves the buffer between memory and the FIFO, writes word 0 back and
// follows the link. Assumes AW <= 32, one memory access in flight, read
// data arriving on a later cycle than its accepted request, and that the
// transmit FIFO is filled and the receive FIFO drained only by this block.
module dchain_walker
    import dchain_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SZ_BITS = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kick,
    input  logic            sreset,
    input  logic [AW-1:0]   base,
    input  logic            tx_dir,
    output dma_state_e      state,
    output logic            set_tx,
    output logic            set_rx,
    output logic            set_du,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ready,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic            fifo_push,
    output logic [31:0]     fifo_wdata,
    input  logic            fifo_full,
    output logic            fifo_pop,
    input  logic [31:0]     fifo_rdata,
    input  logic            fifo_empty
);

    localparam int WCW = SZ_BITS - 1;

    logic [AW-1:0]      cur, bptr, dbuf, dnext, next_desc;
    logic [31:0]        d0;
    logic [SZ_BITS-1:0] dlen;
    logic [SZ_BITS:0]   len_bytes;
    logic [WCW-1:0]     nwords, left;
    logic [1:0]         widx;
    logic               pend, to_card;

    // length decode: zero selects the largest buffer
    always_comb begin
        len_bytes = (dlen == '0) ? {1'b1, {SZ_BITS{1'b0}}} : {1'b0, dlen};
        nwords    = len_bytes[SZ_BITS:2];
    end

    // link selection after close
    always_comb begin
        if (d0[F_CHAIN])     next_desc = dnext;
        else if (d0[F_RING]) next_desc = base;
        else                 next_desc = cur + AW'(16);
    end

    // memory request generation
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = d0;
        case (state)
            ST_DRD: begin
                mem_req  = !pend;
                mem_addr = cur + AW'({widx, 2'b00});
            end
            ST_RDREQ: begin
                mem_req  = !fifo_full;
                mem_addr = bptr;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = bptr;
                mem_wdata = fifo_rdata;
            end
            ST_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {1'b0, d0[30:0]};
            end
            default: ;
        endcase
    end

    // FIFO strobes and event pulses
    always_comb begin
        fifo_push  = (state == ST_RD) && mem_rvalid;
        fifo_wdata = mem_rdata;
        fifo_pop   = (state == ST_WR) && mem_ready;
        set_du     = (state == ST_DCHK) && !d0[F_OWN];
        set_tx     = (state == ST_CLOSE) && mem_ready && !d0[F_NOIRQ] && to_card;
        set_rx     = (state == ST_CLOSE) && mem_ready && !d0[F_NOIRQ] && !to_card;
    end

    // walker state machine
    always_ff @(posedge clk) begin
        if (!rst_n || sreset) begin
            state   <= ST_IDLE;
            cur     <= '0;
            bptr    <= '0;
            dbuf    <= '0;
            dnext   <= '0;
            d0      <= '0;
            dlen    <= '0;
            left    <= '0;
            widx    <= '0;
            pend    <= 1'b0;
            to_card <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (kick) begin
                    cur   <= base;
                    widx  <= '0;
                    pend  <= 1'b0;
                    state <= ST_DRD;
                end
                ST_SUSP: if (kick) begin
                    widx  <= '0;
                    pend  <= 1'b0;
                    state <= ST_DRD;
                end
                ST_DRD: begin
                    if (!pend) begin
                        if (mem_ready) pend <= 1'b1;
                    end else if (mem_rvalid) begin
                        pend <= 1'b0;
                        case (widx)
                            2'd0: d0    <= mem_rdata;
                            2'd1: dlen  <= mem_rdata[SZ_BITS-1:0];
                            2'd2: dbuf  <= mem_rdata[AW-1:0];
                            default: dnext <= mem_rdata[AW-1:0];
                        endcase
                        if (widx == 2'd3) state <= ST_DCHK;
                        else              widx  <= widx + 2'd1;
                    end
                end
                ST_DCHK: begin
                    to_card <= tx_dir;
                    bptr    <= dbuf;
                    left    <= nwords;
                    if (!d0[F_OWN])       state <= ST_SUSP;
                    else if (nwords == '0) state <= ST_CLOSE;
                    else if (tx_dir)      state <= ST_RDREQ;
                    else                  state <= ST_WRREQ;
                end
                ST_RDREQ: if (!fifo_full && mem_ready) state <= ST_RD;
                ST_RD: if (mem_rvalid) begin
                    bptr  <= bptr + AW'(4);
                    left  <= left - WCW'(1);
                    state <= (left == WCW'(1)) ? ST_CLOSE : ST_RDREQ;
                end
                ST_WRREQ: if (!fifo_empty) state <= ST_WR;
                ST_WR: if (mem_ready) begin
                    bptr  <= bptr + AW'(4);
                    left  <= left - WCW'(1);
                    state <= (left == WCW'(1)) ? ST_CLOSE : ST_WRREQ;
                end
                ST_CLOSE: if (mem_ready) begin
                    if (d0[F_LAST]) begin
                        state <= ST_IDLE;
                    end else begin
                        cur   <= next_desc;
                        widx  <= '0;
                        state <= ST_DRD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !pend);

    a_r4_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && !kick && !sreset) |=> (state == ST_SUSP));

    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    a_r6_push_room: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    a_r10_state_code: assert property (@(posedge clk) disable iff (!rst_n)
        state <= ST_CLOSE);

    a_r12_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (state == ST_IDLE));

endmodule

// File: rtl/dchain_dma.sv
// Top of the descriptor-chain DMA engine: joins the register file and the
// descriptor walker. Assumes AW <= 32 and RAW >= 8.
module dchain_dma
    import dchain_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SZ_BITS = 13,
    parameter int RAW     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            irq,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ready,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    input  logic            tx_dir,
    output logic            fifo_push,
    output logic [31:0]     fifo_wdata,
    input  logic            fifo_full,
    output logic            fifo_pop,
    input  logic [31:0]     fifo_rdata,
    input  logic            fifo_empty
);

    dma_state_e  state;
    logic        set_tx, set_rx, set_du, kick, sreset;
    logic [31:0] base;

    dchain_regs #(.RAW(RAW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .state(state),
        .set_tx(set_tx), .set_rx(set_rx), .set_du(set_du),
        .base(base), .kick(kick), .sreset(sreset), .irq(irq)
    );

    dchain_walker #(.AW(AW), .SZ_BITS(SZ_BITS)) walk_i (
        .clk(clk), .rst_n(rst_n), .kick(kick), .sreset(sreset),
        .base(base[AW-1:0]), .tx_dir(tx_dir), .state(state),
        .set_tx(set_tx), .set_rx(set_rx), .set_du(set_du),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty)
    );

endmodule

// File: tb/dchain_dma_tb.sv
`timescale 1ns/1ps
// Bench: small configuration (64-byte max buffer), memory and FIFO models,
// sweeps of buffer length, chain/ring/suspend/reset scenarios.
module dchain_dma_tb_top;

    localparam int SZ = 6;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] NOI = 32'h2, LST = 32'h4, FST = 32'h8, CHN = 32'h10, RNG = 32'h20;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_ready, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_dir = 1'b1;
    logic        fifo_push, fifo_full, fifo_pop, fifo_empty;
    logic [31:0] fifo_wdata, fifo_rdata;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] mem [0:255];
    logic [31:0] cap [0:63];
    logic [31:0] rxq [0:63];
    int ncap = 0, occ = 0, rx_n = 0, rx_idx = 0, full_viol = 0;
    logic [31:0] rd_q = '0;
    logic        rv_q = 1'b0;

    always #2.5 clk = ~clk;

    dchain_dma #(.AW(32), .SZ_BITS(SZ), .RAW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .tx_dir(tx_dir), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty)
    );

    assign mem_ready  = (cyc % 4) != 3;
    assign mem_rvalid = rv_q;
    assign mem_rdata  = rd_q;
    assign fifo_full  = occ >= 2;
    assign fifo_empty = rx_idx >= rx_n;
    assign fifo_rdata = rxq[rx_idx[5:0]];

    // memory, FIFO and cycle models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rv_q <= rst_n && mem_req && mem_ready && !mem_we;
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        rd_q <= mem[mem_addr[9:2]];
        end
        if (fifo_push) begin
            if (fifo_full) full_viol <= full_viol + 1;
            cap[ncap[5:0]] <= fifo_wdata;
            ncap <= ncap + 1;
        end
        occ <= occ + (fifo_push ? 1 : 0) - ((occ != 0 && cyc % 3 == 0) ? 1 : 0);
        if (fifo_pop) rx_idx <= rx_idx + 1;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=%0d cycles expected=end of run", cyc);
        summary();
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] s;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            rd(8'h88, s);
            if (s[16:13] <= 4'd1) break;
        end
    endtask

    function automatic logic [31:0] sts(input bit t, input bit r, input bit du, input int st);
        return {15'd0, 4'(st), 3'd0, du, t | r, 3'd0, du, 2'd0, r, t};
    endfunction

    task automatic put_desc(input int a, input logic [31:0] w0, w1, w2, w3);
        mem[a/4] = w0; mem[a/4+1] = w1; mem[a/4+2] = w2; mem[a/4+3] = w3;
    endtask

    initial begin
        logic [31:0] v;
        int bad, nw, c0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h80, v); chk(v == 0, "R1 control", v, 0);
        rd(8'h84, v); chk(v == 0, "R1 base", v, 0);
        rd(8'h88, v); chk(v == 0, "R1 status", v, 0);
        rd(8'h8C, v); chk(v == 0, "R1 enable", v, 0);
        chk(irq == 0 && !mem_req && !fifo_push && !fifo_pop, "R1 idle outputs", {29'd0, irq, mem_req, fifo_push}, 0);

        // R2: register readback, fixed burst alone does not start
        wr(8'h84, 32'h0000_0040); rd(8'h84, v); chk(v == 32'h40, "R2 base readback", v, 32'h40);
        wr(8'h84, 32'h0);
        wr(8'h8C, 32'h3); rd(8'h8C, v); chk(v == 32'h3, "R2 enable readback", v, 32'h3);
        wr(8'h80, 32'h3); rd(8'h80, v); chk(v == 32'h0, "R2 R12 bit0 write resets control", v, 0);
        wr(8'h80, 32'h2); rd(8'h80, v); chk(v == 32'h2, "R2 fixed burst readback", v, 32'h2);
        rd(8'h88, v); chk(v == 0, "R3 no start without run bit", v, 0);

        // R3 R5 R6 R7 R8 R11: transmit sweep of every length, 0 = 64 bytes
        tx_dir = 1'b1;
        for (int len = 4; len <= 64; len += 4) begin
            nw = len / 4;
            for (int i = 0; i < 16; i++) mem[64 + i] = 32'hA500_0000 + (len << 8) + i;
            put_desc(0, OWN | LST | FST | CHN, (len == 64) ? 32'h0 : len, 32'h100, 32'h0);
            ncap = 0;
            wr(8'h80, 32'h80);
            wait_stop();
            chk(ncap == nw, "R5 word count", ncap, nw);
            bad = 0;
            for (int i = 0; i < nw; i++) if (cap[i] != 32'hA500_0000 + (len << 8) + i) bad++;
            chk(bad == 0, "R6 transmit order", bad, 0);
            chk(mem[0] == (LST | FST | CHN), "R7 writeback own cleared", mem[0], LST | FST | CHN);
            rd(8'h88, v); chk(v == sts(1, 0, 0, 0), "R8 R10 tx done status", v, sts(1, 0, 0, 0));
            chk(irq == 1, "R11 irq on tx done", irq, 1);
            wr(8'h88, 32'hFFFF_FFFF);
            rd(8'h88, v); chk(v == 0, "R10 write one clears", v, 0);
            chk(irq == 0, "R11 irq low after clear", irq, 0);
        end
        chk(full_viol == 0, "R6 no push while full", full_viol, 0);

        // R6 R8 R9: receive through a chain in non-sequential order
        tx_dir = 1'b0;
        for (int j = 0; j < 9; j++) rxq[j] = 32'hC0DE_0000 + j;
        rx_idx = 0; rx_n = 9;
        for (int i = 128; i < 176; i++) mem[i] = '0;
        put_desc('h00, OWN | FST | CHN, 8, 32'h200, 32'h20);
        put_desc('h20, OWN | CHN | NOI, 12, 32'h240, 32'h10);
        put_desc('h10, OWN | CHN | LST | RNG, 16, 32'h280, 32'h0);
        wr(8'h80, 32'h80);
        wait_stop();
        chk(rx_idx == 9, "R6 receive pops", rx_idx, 9);
        bad = 0;
        for (int j = 0; j < 2; j++) if (mem[128 + j] != rxq[j]) bad++;
        for (int j = 0; j < 3; j++) if (mem[144 + j] != rxq[2 + j]) bad++;
        for (int j = 0; j < 4; j++) if (mem[160 + j] != rxq[5 + j]) bad++;
        chk(bad == 0, "R9 chain link order", bad, 0);
        chk(mem[146 + 1] == 0, "R5 no write past length", mem[147], 0);
        chk(mem[8] == (CHN | NOI), "R7 writeback keeps flags", mem[8], CHN | NOI);
        rd(8'h88, v); chk(v == sts(0, 1, 0, 0), "R8 rx done status", v, sts(0, 1, 0, 0));
        wr(8'h88, 32'hFFFF_FFFF);

        // R4 R9: ring mode wraps to base, meets host-owned descriptor
        tx_dir = 1'b1;
        mem[64] = 32'h1111_0000;
        mem[80] = 32'h2222_0000; mem[81] = 32'h2222_0001;
        put_desc('h00, OWN, 4, 32'h100, 32'h0);
        put_desc('h10, OWN | RNG, 8, 32'h140, 32'h0);
        ncap = 0;
        wr(8'h80, 32'h80);
        wait_stop();
        rd(8'h88, v); chk(v == sts(1, 0, 1, 1), "R4 R9 ring wrap suspends", v, sts(1, 0, 1, 1));
        chk(ncap == 3 && cap[0] == 32'h1111_0000 && cap[2] == 32'h2222_0001, "R9 sequential then wrap", ncap, 3);
        wr(8'h88, 32'h11);
        mem[0] = OWN | LST;
        c0 = ncap;
        wr(8'h80, 32'h80);
        wait_stop();
        rd(8'h88, v); chk(v == sts(1, 0, 0, 0), "R4 resume refetches", v, sts(1, 0, 0, 0));
        chk(ncap == c0 + 1, "R4 resumed transfer", ncap, c0 + 1);
        wr(8'h88, 32'hFFFF_FFFF);

        // R4 R11 R12: unowned first descriptor at another base, then soft reset
        wr(8'h84, 32'h40);
        wr(8'h8C, 32'h10);
        put_desc('h40, LST | 32'h1, 8, 32'h100, 32'h0);
        ncap = 0;
        wr(8'h80, 32'h80);
        wait_stop();
        rd(8'h88, v); chk(v == sts(0, 0, 1, 1), "R4 unavailable status", v, sts(0, 0, 1, 1));
        chk(ncap == 0, "R4 no buffer access", ncap, 0);
        chk(mem[16] == (LST | 32'h1), "R4 no writeback", mem[16], LST | 32'h1);
        chk(irq == 1, "R11 irq on unavailable", irq, 1);
        repeat (20) @(negedge clk);
        rd(8'h88, v); chk(v[16:13] == 1, "R4 stays suspended", v[16:13], 1);
        wr(8'h80, 32'h81);
        rd(8'h80, v); chk(v == 0, "R12 control cleared", v, 0);
        rd(8'h88, v); chk(v == 0, "R12 status and state cleared", v, 0);
        chk(irq == 0, "R12 irq low", irq, 0);

        summary();
    end

endmodule